// File: doc/BRIEF.md
# Parallel Host Port Register Bank

This block is the peripheral side of an 8-bit parallel host port. The port works like EPP. The host drives three lines: an active-low address strobe, an active-low data strobe and a direction line. One 8-bit bidirectional lane carries either an address byte or a data byte. The block answers each strobe with a wait handshake.

The host first writes an address. It then reads or writes the byte in the register that address selects. On the fabric side, the host-writable registers appear as one flattened output vector, and one flattened input vector is sampled for host reads.

The strobes and the direction line are asynchronous to the system clock. A two-flop synchronizer resynchronizes them, and every handshake decision is made in the clock domain. The fabric registers run on the rising clock edge. An active-high chip enable gates them, and an active-high reset clears them. The register count `NREGS` may be 1 to 256, which keeps the address inside the 8-bit lane.

Top module: `epp_regbank`

## Requirements
- R1: An address-strobe cycle with `hst_rd`=0 latches the low `AW` bits of the bus as the current address. `AW` is `max(1, ceil(log2(NREGS)))`, which is 3 for the default `NREGS`=5.
- R2: `hst_wait` rises on the third rising clock edge after a strobe falls. It then stays high for as long as that strobe is held low.
- R3: Once `hst_wait` is high, it falls on the third rising clock edge after both strobes are high again.
- R4: A data-strobe cycle with `hst_rd`=0 stores the bus byte into `fab_out[8*a +: 8]`, where `a` is the current address. The byte changes on the same edge that raises `hst_wait`.
- R5: A data-strobe cycle with `hst_rd`=1 drives the bus with byte `a` of the sampled input register while `hst_wait` is high. The block drives the bus at no other time outside R6.
- R6: An address-strobe cycle with `hst_rd`=1 drives the current address, zero-extended to 8 bits, onto the bus while `hst_wait` is high.
- R7: A data write to an address at or above `NREGS` leaves `fab_out` unchanged. A data read from such an address returns 0x00.
- R8: While `ce`=0, `fab_out` holds its value and `fab_in` is not resampled. Reads then return the value captured on the last edge with `ce`=1. The handshake keeps running.
- R9: Reset clears `fab_out`, the sampled input register and the address, and drives `hst_wait` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ce | input | 1 | Chip enable for the fabric registers |
| hst_astb_n | input | 1 | Host address strobe, active low |
| hst_dstb_n | input | 1 | Host data strobe, active low |
| hst_rd | input | 1 | Direction: 1 = host reads, 0 = host writes |
| hst_wait | output | 1 | Handshake: 1 = byte taken or presented |
| hst_bus | inout | 8 | Shared address/data lane |
| fab_in | input | 8*NREGS | Flattened bytes the host reads |
| fab_out | output | 8*NREGS | Flattened bytes the host writes |

## Verification
After a strobe falls, the bench counts falling clock edges until `hst_wait` is seen high. It expects exactly three, because the synchronizer takes two edges and the handshake register takes one. The release works the same way: the bench counts three edges from the release until `hst_wait` is low.

A written byte shows up in `fab_out` on the same edge that raises `hst_wait`. It is therefore checked once the handshake completes. A read byte is sampled from the bus while `hst_wait` is high, just before the strobe is released.

`fab_in` and `ce` are changed at least two edges before the next strobe, so the sampled input register is settled when the read is decided.

// File: rtl/epp_pkg.sv
package epp_pkg;
    typedef enum logic {
        HS_IDLE = 1'b0,
        HS_HOLD = 1'b1
    } hs_state_e;
endpackage

// File: rtl/epp_sync.sv
module epp_sync #(
    parameter int W = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] m_q, s_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            m_q <= RST_VAL;
            s_q <= RST_VAL;
        end else begin
            m_q <= din;
            s_q <= m_q;
        end
    end

    assign dout = s_q;
endmodule

// File: rtl/epp_hs_ctrl.sv
module epp_hs_ctrl
    import epp_pkg::*;
#(
    parameter int AW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          astb_n_s,
    input  logic          dstb_n_s,
    input  logic          rd_s,
    input  logic [7:0]    bus_in,
    input  logic [7:0]    rd_byte,
    output logic [AW-1:0] addr,
    output logic          wr_en,
    output logic          wait_o,
    output logic          drive,
    output logic [7:0]    obyte
);
    typedef struct packed {
        hs_state_e     st;
        logic          wt;
        logic          drv;
        logic [AW-1:0] adr;
        logic [7:0]    ob;
    } hs_t;

    hs_t s_d, s_q;

    always_comb begin
        s_d   = s_q;
        wr_en = 1'b0;
        case (s_q.st)
            HS_IDLE: begin
                if (!astb_n_s) begin
                    s_d.st = HS_HOLD;
                    s_d.wt = 1'b1;
                    if (rd_s) begin
                        s_d.ob  = 8'(s_q.adr);
                        s_d.drv = 1'b1;
                    end else begin
                        s_d.adr = bus_in[AW-1:0];
                    end
                end else if (!dstb_n_s) begin
                    s_d.st = HS_HOLD;
                    s_d.wt = 1'b1;
                    if (rd_s) begin
                        s_d.ob  = rd_byte;
                        s_d.drv = 1'b1;
                    end else begin
                        wr_en = 1'b1;
                    end
                end
            end
            default: begin
                if (astb_n_s && dstb_n_s) begin
                    s_d.st  = HS_IDLE;
                    s_d.wt  = 1'b0;
                    s_d.drv = 1'b0;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= '{st: HS_IDLE, wt: 1'b0, drv: 1'b0, adr: '0, ob: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign addr   = s_q.adr;
    assign wait_o = s_q.wt;
    assign drive  = s_q.drv;
    assign obyte  = s_q.ob;

    assert_wait_rise_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(wait_o) |-> $past(!astb_n_s || !dstb_n_s));
    assert_wait_fall_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(wait_o) |-> $past(astb_n_s && dstb_n_s));
    assert_drive_in_cycle_R5: assert property (@(posedge clk) disable iff (rst)
        drive |-> wait_o);
    assert_write_acked_R4: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> wait_o);
endmodule

// File: rtl/epp_regfile.sv
module epp_regfile #(
    parameter int NREGS = 5,
    parameter int AW    = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ce,
    input  logic               wr_en,
    input  logic [AW-1:0]      addr,
    input  logic [7:0]         wr_byte,
    output logic [7:0]         rd_byte,
    input  logic [8*NREGS-1:0] fab_in,
    output logic [8*NREGS-1:0] fab_out
);
    localparam int VW = 8 * NREGS;
    localparam logic [AW:0] NLIM = (AW+1)'(NREGS);

    logic [VW-1:0] in_d, in_q;

    for (genvar g = 0; g < NREGS; g++) begin : g_reg
        logic [7:0] r_d, r_q;
        always_comb begin
            r_d = r_q;
            if (ce && wr_en && addr == AW'(g)) r_d = wr_byte;
        end
        always_ff @(posedge clk) begin
            if (rst) r_q <= '0;
            else     r_q <= r_d;
        end
        assign fab_out[8*g +: 8] = r_q;
    end

    always_comb begin
        in_d = ce ? fab_in : in_q;
    end

    always_ff @(posedge clk) begin
        if (rst) in_q <= '0;
        else     in_q <= in_d;
    end

    always_comb begin
        rd_byte = 8'h00;
        for (int i = 0; i < NREGS; i++) begin
            if (addr == AW'(i)) rd_byte = in_q[8*i +: 8];
        end
    end

    assert_ce_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !ce |=> $stable(fab_out));
    assert_oor_ignored_R7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && {1'b0, addr} >= NLIM) |=> $stable(fab_out));
endmodule

// File: rtl/epp_regbank.sv
module epp_regbank #(
    parameter int NREGS = 5
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ce,
    input  logic               hst_astb_n,
    input  logic               hst_dstb_n,
    input  logic               hst_rd,
    output logic               hst_wait,
    inout  wire  [7:0]         hst_bus,
    input  logic [8*NREGS-1:0] fab_in,
    output logic [8*NREGS-1:0] fab_out
);
    localparam int AW = (NREGS > 1) ? $clog2(NREGS) : 1;

    logic [2:0]    sync_o;
    logic [AW-1:0] addr;
    logic          wr_en, drive;
    logic [7:0]    obyte, rd_byte, bus_in;

    epp_sync #(.W(3), .RST_VAL(3'b110)) u_sync (
        .clk (clk),
        .rst (rst),
        .din ({hst_astb_n, hst_dstb_n, hst_rd}),
        .dout(sync_o)
    );

    assign bus_in = hst_bus;

    epp_hs_ctrl #(.AW(AW)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .astb_n_s(sync_o[2]),
        .dstb_n_s(sync_o[1]),
        .rd_s    (sync_o[0]),
        .bus_in  (bus_in),
        .rd_byte (rd_byte),
        .addr    (addr),
        .wr_en   (wr_en),
        .wait_o  (hst_wait),
        .drive   (drive),
        .obyte   (obyte)
    );

    epp_regfile #(.NREGS(NREGS), .AW(AW)) u_rf (
        .clk    (clk),
        .rst    (rst),
        .ce     (ce),
        .wr_en  (wr_en),
        .addr   (addr),
        .wr_byte(bus_in),
        .rd_byte(rd_byte),
        .fab_in (fab_in),
        .fab_out(fab_out)
    );

    assign hst_bus = drive ? obyte : 8'hzz;
endmodule

// File: tb/sim_epp_regbank.sv
module sim_epp_regbank;
    localparam int CLK_PERIOD = 10;
    localparam int N  = 5;
    localparam int VW = 8 * N;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ce = 1'b1;
    logic astb_n = 1'b1;
    logic dstb_n = 1'b1;
    logic rd = 1'b0;
    logic tb_en = 1'b0;
    logic [7:0] tb_val = 8'h00;
    logic [VW-1:0] fab_in = '0;
    logic [VW-1:0] fab_out;
    logic hst_wait;
    wire  [7:0] hst_bus;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    logic [7:0] exp_out [N];
    logic [2:0] exp_addr;

    assign hst_bus = tb_en ? tb_val : 8'hzz;

    always #(CLK_PERIOD/2) clk = ~clk;

    epp_regbank #(.NREGS(N)) u0 (
        .clk(clk), .rst(rst), .ce(ce),
        .hst_astb_n(astb_n), .hst_dstb_n(dstb_n), .hst_rd(rd),
        .hst_wait(hst_wait), .hst_bus(hst_bus),
        .fab_in(fab_in), .fab_out(fab_out)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [VW-1:0] model_out();
        logic [VW-1:0] v;
        for (int i = 0; i < N; i++) v[8*i +: 8] = exp_out[i];
        return v;
    endfunction

    function automatic logic [7:0] model_read(input logic [2:0] a, input logic [VW-1:0] src);
        if (int'(a) < N) return src[8*a +: 8];
        return 8'h00;
    endfunction

    task automatic host(input bit is_addr, input bit is_rd, input logic [7:0] wv,
                        input int hold, output logic [7:0] rv);
        int cnt;
        @(negedge clk);
        rd = is_rd;
        tb_en = !is_rd;
        tb_val = wv;
        if (is_addr) astb_n = 1'b0; else dstb_n = 1'b0;
        cnt = 0;
        do begin @(negedge clk); cnt++; end while (!hst_wait && cnt < 20);
        chk(cnt == 3, "R2 wait rise latency", 64'(cnt), 64'd3);
        for (int h = 0; h < hold; h++) @(negedge clk);
        if (hold > 0) chk(hst_wait == 1'b1, "R2 wait held during stretch", 64'(hst_wait), 64'd1);
        rv = hst_bus;
        astb_n = 1'b1;
        dstb_n = 1'b1;
        tb_en = 1'b0;
        cnt = 0;
        do begin @(negedge clk); cnt++; end while (hst_wait && cnt < 20);
        chk(cnt == 3, "R3 wait fall latency", 64'(cnt), 64'd3);
        @(negedge clk);
    endtask

    initial begin
        logic [7:0] rv;
        for (int i = 0; i < N; i++) exp_out[i] = 8'h00;
        exp_addr = 3'd0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(fab_out == '0, "R9 fab_out after reset", 64'(fab_out), 64'd0);
        chk(hst_wait == 1'b0, "R9 wait after reset", 64'(hst_wait), 64'd0);
        host(1'b1, 1'b1, 8'h00, 0, rv);
        chk(rv == 8'h00, "R9 address after reset", 64'(rv), 64'd0);

        // directed: write then read back address, write data, stretch
        host(1'b1, 1'b0, 8'h03, 0, rv); exp_addr = 3'd3;
        host(1'b1, 1'b1, 8'h00, 0, rv);
        chk(rv == 8'h03, "R1 R6 address readback", 64'(rv), 64'h03);
        host(1'b0, 1'b0, 8'hA5, 6, rv); exp_out[3] = 8'hA5;
        chk(fab_out == model_out(), "R4 data write", 64'(fab_out), 64'(model_out()));

        // R1: upper bus bits dropped (0xFC -> address 4)
        host(1'b1, 1'b0, 8'hFC, 0, rv); exp_addr = 3'd4;
        host(1'b1, 1'b1, 8'h00, 0, rv);
        chk(rv == 8'h04, "R1 low bits latched", 64'(rv), 64'h04);

        // R7: out-of-range write and read
        host(1'b1, 1'b0, 8'h06, 0, rv); exp_addr = 3'd6;
        host(1'b0, 1'b0, 8'h77, 0, rv);
        chk(fab_out == model_out(), "R7 out-of-range write ignored", 64'(fab_out), 64'(model_out()));
        fab_in = {VW{1'b1}};
        repeat (3) @(negedge clk);
        host(1'b0, 1'b1, 8'h00, 0, rv);
        chk(rv == 8'h00, "R7 out-of-range read", 64'(rv), 64'h00);

        // R8: ce low holds both sides
        host(1'b1, 1'b0, 8'h01, 0, rv); exp_addr = 3'd1;
        fab_in = 40'h11_22_33_44_55;
        repeat (3) @(negedge clk);
        ce = 1'b0;
        fab_in = 40'h99_88_77_66_EE;
        repeat (3) @(negedge clk);
        host(1'b0, 1'b0, 8'h3C, 0, rv);
        chk(fab_out == model_out(), "R8 write blocked by ce", 64'(fab_out), 64'(model_out()));
        host(1'b0, 1'b1, 8'h00, 0, rv);
        chk(rv == 8'h44, "R8 read returns held input", 64'(rv), 64'h44);
        ce = 1'b1;
        repeat (3) @(negedge clk);

        // constrained random mix
        void'($urandom(32'd1234));
        for (int it = 0; it < 60; it++) begin
            int op;
            op = $urandom_range(0, 3);
            if (op == 0) begin
                logic [7:0] a;
                a = 8'($urandom_range(0, 7)) | (8'($urandom_range(0, 31)) << 3);
                host(1'b1, 1'b0, a, 0, rv);
                exp_addr = a[2:0];
            end else if (op == 1) begin
                logic [7:0] d;
                d = 8'($urandom);
                host(1'b0, 1'b0, d, 0, rv);
                if (int'(exp_addr) < N) exp_out[exp_addr] = d;
                chk(fab_out == model_out(), "R4 R7 random write", 64'(fab_out), 64'(model_out()));
            end else if (op == 2) begin
                fab_in = {$urandom, 8'($urandom)};
                repeat (3) @(negedge clk);
                host(1'b0, 1'b1, 8'h00, $urandom_range(0, 3), rv);
                chk(rv == model_read(exp_addr, fab_in), "R5 R7 random read",
                    64'(rv), 64'(model_read(exp_addr, fab_in)));
            end else begin
                host(1'b1, 1'b1, 8'h00, 0, rv);
                chk(rv == 8'(exp_addr), "R6 random address read", 64'(rv), 64'(exp_addr));
            end
        end

        // R9: reset mid-run clears outputs
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(fab_out == '0, "R9 fab_out cleared", 64'(fab_out), 64'd0);
        chk(hst_wait == 1'b0, "R9 wait cleared", 64'(hst_wait), 64'd0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule